// File: doc/BRIEF.md
# Low-Order Interleaved Memory Scheduler

This block accepts a stream of single-word read and write requests and spreads them across 2^K memory banks. The least significant K bits of the word address pick the bank, so a run of ascending addresses visits every bank in turn. Each bank is a behavioural memory that stays occupied for a fixed cycle time of CYC clock slots after it takes a request. The shared bus moves one request per slot, which is faster than any single bank can cycle, so several banks work at once and an ascending burst, such as a cache-line fill, runs at one word per slot.

Requests enter on a valid/ready port. Ready depends on the address being offered: it is high when the addressed bank is idle and low while that bank is still inside its cycle time. While valid is high and ready is low, the requester must hold the command, address and write data unchanged. A transfer takes place in any cycle where both are high. Read data returns on a response port with a valid strobe and no back-pressure. The consumer must take a word in every cycle in which rsp_valid is high. Responses arrive in the same order the reads were accepted. Writes produce no response.

Top module: `ilv_sched`

## Requirements
- R1: The bank number is req_addr[K_BITS-1:0] and the word inside that bank is req_addr[ADDR_W-1:K_BITS]. Two requests with equal low K bits use the same bank and contend for it. Requests with different low K bits never contend.
- R2: Suppose a request is accepted in cycle c. Then a later request to the same bank is not accepted before cycle c+CYC. req_ready is high exactly when the addressed bank has no cycle time left.
- R3: A read accepted in cycle c shows its data on rsp_data, with rsp_valid high, in cycle c+CYC+1.
- R4: Responses come out in the order the reads were accepted. Each one carries the word most recently written to that full address.
- R5: An accepted write never raises rsp_valid.
- R6: A run of 2^K or more requests to ascending consecutive addresses is accepted one per cycle with no stall, given CYC <= 2^K. The matching read responses appear in consecutive cycles.
- R7: While rst_n is low and in the first cycle after it rises, rsp_valid is low and req_ready is high. A read still in flight when reset is asserted never produces a response.
- R8: At most one request is accepted per cycle. A request held under back-pressure is taken exactly once. The requester keeps req_write, req_addr and req_wdata stable while req_valid is high and req_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bus slot per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | Addressed bank is free; the request is taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address; low K_BITS select the bank |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data present this cycle |
| rsp_data | output | DATA_W | Read data, in acceptance order |

## Verification
Acceptance is combinational: the bench puts a request on the port at a falling edge and reads req_ready one nanosecond later. It records the current cycle number as the acceptance cycle when ready is high. Each read response is then expected exactly CYC+1 cycles after its acceptance cycle. A monitor stamps every rsp_valid cycle at the falling edge, when the registered output is stable, and compares those stamps against the recorded acceptance cycles. Bank contention is measured the same way: a second request to the same bank must be accepted exactly CYC cycles after the first. After reset, the idle ready level is sampled in the first cycle, and the absence of responses is checked over a window longer than one read latency.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  // Bits needed by a down-counter that starts at cyc-1.
  function automatic int cnt_bits(input int cyc);
    return (cyc < 3) ? 1 : $clog2(cyc);
  endfunction
endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int WORD_W = 6,
  parameter int DATA_W = 16,
  parameter int CYC    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic              wr,
  input  logic [WORD_W-1:0] word,
  input  logic [DATA_W-1:0] wdata,
  output logic              busy,
  output logic [DATA_W-1:0] rdata
);
  localparam int CW    = ilv_pkg::cnt_bits(CYC);
  localparam int DEPTH = 1 << WORD_W;

  logic [CW-1:0]     cnt_q;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  // Remaining cycle time; zero means free for a new access.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (issue)      cnt_q <= CW'(CYC - 1);
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (issue && wr)  mem[word] <= wdata;
    if (issue && !wr) rdata_q   <= mem[word];
  end

  assign busy  = (cnt_q != 0);
  assign rdata = rdata_q;
endmodule

// File: rtl/ilv_tagq.sv
module ilv_tagq #(
  parameter int TW    = 2,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [TW-1:0] push_tag,
  input  logic          pop,
  output logic [TW-1:0] head_tag,
  output logic          empty
);
  localparam int PW = (DEPTH < 2) ? 1 : $clog2(DEPTH);

  logic [TW-1:0] slot [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [PW:0]   fill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      fill_q <= '0;
    end else begin
      if (push) wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (pop)  rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      case ({push, pop})
        2'b10:   fill_q <= fill_q + 1'b1;
        2'b01:   fill_q <= fill_q - 1'b1;
        default: fill_q <= fill_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) slot[wp_q] <= push_tag;
  end

  assign head_tag = slot[rp_q];
  assign empty    = (fill_q == 0);
endmodule

// File: rtl/ilv_sched.sv
module ilv_sched #(
  parameter int K_BITS = 2,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int CYC    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int NB     = 1 << K_BITS;
  localparam int WORD_W = ADDR_W - K_BITS;

  logic [K_BITS-1:0] sel;
  logic [WORD_W-1:0] word;
  logic [NB-1:0]     busy_v;
  logic [DATA_W-1:0] rdata_a [NB];
  logic              accept;
  logic [K_BITS-1:0] head;
  logic              q_empty;
  logic              pop;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;

  // Low-order interleave: bank from the bottom bits, word from the rest.
  assign sel       = req_addr[K_BITS-1:0];
  assign word      = req_addr[ADDR_W-1:K_BITS];
  assign req_ready = !busy_v[sel];
  assign accept    = req_valid && req_ready;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    ilv_bank #(
      .WORD_W(WORD_W),
      .DATA_W(DATA_W),
      .CYC   (CYC)
    ) bank_i (
      .clk  (clk),
      .rst_n(rst_n),
      .issue(accept && (sel == K_BITS'(b))),
      .wr   (req_write),
      .word (word),
      .wdata(req_wdata),
      .busy (busy_v[b]),
      .rdata(rdata_a[b])
    );
  end

  // Bank tags of outstanding reads, oldest at the head.
  ilv_tagq #(
    .TW   (K_BITS),
    .DEPTH(NB)
  ) tagq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (accept && !req_write),
    .push_tag(sel),
    .pop     (pop),
    .head_tag(head),
    .empty   (q_empty)
  );

  // Equal latency per read: the oldest bank finishes first, one per slot.
  assign pop = !q_empty && !busy_v[head];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid_q <= 1'b0;
    else        rsp_valid_q <= pop;
  end

  always_ff @(posedge clk) begin
    if (pop) rsp_data_q <= rdata_a[head];
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
endmodule

// File: rtl/ilv_sched_chk.sv
module ilv_sched_chk #(
  parameter int K_BITS = 2,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int CYC    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid
);
  localparam int NB = 1 << K_BITS;
  localparam int CW = ilv_pkg::cnt_bits(CYC);

  logic          acc;
  logic [CW-1:0] occ [NB];
  logic [CYC:0]  rd_line;

  assign acc = req_valid && req_ready;

  // Independent occupancy model: cycles left per bank since its last acceptance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) occ[b] <= '0;
      rd_line <= '0;
    end else begin
      for (int b = 0; b < NB; b++) begin
        if (acc && req_addr[K_BITS-1:0] == K_BITS'(b)) occ[b] <= CW'(CYC - 1);
        else if (occ[b] != 0)                          occ[b] <= occ[b] - 1'b1;
      end
      rd_line <= {rd_line[CYC-1:0], acc && !req_write};
    end
  end

  assert_busy_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (occ[req_addr[K_BITS-1:0]] != 0) |-> !req_ready);

  assert_free_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (occ[req_addr[K_BITS-1:0]] == 0) |-> req_ready);

  assert_rsp_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == rd_line[CYC]);

  assert_no_write_rsp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_line[CYC] |-> !rsp_valid);

  assert_reset_idle_R7: assert property (@(posedge clk)
    !rst_n |=> !rsp_valid);

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)
                                   && $stable(req_write) && $stable(req_wdata)));
endmodule

bind ilv_sched ilv_sched_chk #(
  .K_BITS(K_BITS),
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .CYC   (CYC)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_write(req_write),
  .req_addr (req_addr),
  .req_wdata(req_wdata),
  .rsp_valid(rsp_valid)
);

// File: tb/ilv_sched_tb_top.sv
module ilv_sched_tb_top;
  localparam int K_BITS = 2;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int CYC    = 4;
  localparam int NB     = 1 << K_BITS;

  // {address, data}; neighbours 0x03/0x07 and 0x3E/0x3F give mixed contention.
  localparam logic [23:0] TBL [8] = '{
    24'h03_A103, 24'h07_A207, 24'h0C_A30C, 24'h0D_A40D,
    24'h01_A501, 24'h05_A605, 24'h3E_A73E, 24'h3F_A83F
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              rsp_valid;
  logic [DATA_W-1:0] rsp_data;

  int          cyc = 0;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;
  int          rd_n = 0, rsp_n = 0, chk_ptr = 0;
  int          rd_acc [64];
  logic [15:0] rd_exp [64];
  int          rsp_c  [64];
  logic [15:0] rsp_d  [64];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ilv_sched #(
    .K_BITS(K_BITS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CYC(CYC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  always @(negedge clk) begin
    if (rsp_valid && rsp_n < 64) begin
      rsp_d[rsp_n] = rsp_data;
      rsp_c[rsp_n] = cyc;
      rsp_n++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Offer one request, hold it until accepted, return the acceptance cycle.
  task automatic do_req(input bit wr, input logic [7:0] a, input logic [15:0] d,
                        input logic [15:0] exp, input bit track, output int acc);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    acc = cyc;
    if (!wr && track && rd_n < 64) begin
      rd_acc[rd_n] = cyc;
      rd_exp[rd_n] = exp;
      rd_n++;
    end
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Compare all new responses: count, data and order, due cycle.
  task automatic drain_check();
    repeat (CYC + 3) @(negedge clk);
    check(rsp_n == rd_n, "R5 R8 response count", rsp_n, rd_n);
    for (int i = chk_ptr; i < rd_n; i++) begin
      check(rsp_d[i] == rd_exp[i], "R4 data in order", rsp_d[i], rd_exp[i]);
      check(rsp_c[i] == rd_acc[i] + CYC + 1, "R3 latency", rsp_c[i], rd_acc[i] + CYC + 1);
    end
    chk_ptr = rd_n;
  endtask

  initial begin
    int a0, a1, n0, first;
    // R7: idle levels during reset and in the first cycle after release
    repeat (2) @(negedge clk);
    check(req_ready == 1'b1, "R7 ready in reset", req_ready, 1);
    check(rsp_valid == 1'b0, "R7 rsp_valid in reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R7 ready after reset", req_ready, 1);
    check(rsp_valid == 1'b0, "R7 rsp_valid after reset", rsp_valid, 0);

    // Table walk: writes, then reads in table order (R4, R3, R5)
    for (int i = 0; i < 8; i++) do_req(1'b1, TBL[i][23:16], TBL[i][15:0], 16'h0, 1'b1, a0);
    idle(CYC + 2);
    check(rsp_n == 0, "R5 writes silent", rsp_n, 0);
    for (int i = 0; i < 8; i++) do_req(1'b0, TBL[i][23:16], 16'h0, TBL[i][15:0], 1'b1, a0);
    idle(0);
    drain_check();

    // R6: ascending stream of 2*NB words, no stall, back-to-back responses
    for (int i = 0; i < 2 * NB; i++) do_req(1'b1, 8'h10 + 8'(i), 16'h1000 + 16'(i), 16'h0, 1'b1, a0);
    idle(CYC);
    n0 = rsp_n;
    first = 0;
    for (int i = 0; i < 2 * NB; i++) begin
      do_req(1'b0, 8'h10 + 8'(i), 16'h0, 16'h1000 + 16'(i), 1'b1, a1);
      if (i == 0) first = a1;
      else check(a1 == first + i, "R6 accept every cycle", a1, first + i);
    end
    idle(0);
    drain_check();
    for (int i = n0 + 1; i < n0 + 2 * NB; i++)
      check(rsp_c[i] == rsp_c[i-1] + 1, "R6 back-to-back responses", rsp_c[i], rsp_c[i-1] + 1);

    // R2: same bank waits CYC cycles
    idle(CYC);
    do_req(1'b1, 8'h20, 16'h2020, 16'h0, 1'b1, a0);
    do_req(1'b1, 8'h24, 16'h2424, 16'h0, 1'b1, a1);
    check(a1 == a0 + CYC, "R2 same-bank spacing", a1 - a0, CYC);

    // R1: low bits select the bank
    idle(CYC);
    do_req(1'b1, 8'h30, 16'h3030, 16'h0, 1'b1, a0);
    do_req(1'b1, 8'h31, 16'h3131, 16'h0, 1'b1, a1);
    check(a1 == a0 + 1, "R1 different banks no stall", a1 - a0, 1);
    idle(CYC);
    do_req(1'b1, 8'h32, 16'h3232, 16'h0, 1'b1, a0);
    do_req(1'b1, 8'h36, 16'h3636, 16'h0, 1'b1, a1);
    check(a1 == a0 + CYC, "R1 same low bits stall", a1 - a0, CYC);

    // R4: read after write to one address returns the new word
    idle(CYC);
    do_req(1'b1, 8'h44, 16'hBEEF, 16'h0, 1'b1, a0);
    do_req(1'b0, 8'h44, 16'h0, 16'hBEEF, 1'b1, a1);
    check(a1 == a0 + CYC, "R2 read waits on write", a1 - a0, CYC);
    do_req(1'b0, 8'h24, 16'h0, 16'h2424, 1'b1, a1);
    do_req(1'b0, 8'h31, 16'h0, 16'h3131, 1'b1, a1);
    idle(0);
    drain_check();

    // R7: reset with a read in flight drops it and frees the bank
    do_req(1'b0, 8'h10, 16'h0, 16'h0, 1'b0, a0);
    @(negedge clk);
    rst_n = 1'b0; req_valid = 1'b0;
    repeat (2) @(negedge clk);
    n0 = rsp_n;
    rst_n = 1'b1;
    req_addr = 8'h10;
    @(negedge clk);
    check(req_ready == 1'b1, "R7 bank free after reset", req_ready, 1);
    repeat (CYC + 3) @(negedge clk);
    check(rsp_n == n0, "R7 in-flight read dropped", rsp_n, n0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R8 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule